// File: doc/BRIEF.md
# Programmable Serial CRC Engine

This block is the bit-serial CRC stage of a bus master that talks to remote sensors over a two-wire line. A single frame engine covers both directions. When sending, it takes a parallel data word of 8 to 16 bits and shifts it out one bit per clock, most significant bit first. It then appends the CRC it computed over that word, so the check bits directly follow the last data bit on the wire. When receiving, it consumes serial bits whenever the line side marks them valid. It builds its own CRC over the data portion, collects the check bits that follow, and compares the two when the frame ends.

The CRC length (0 to 8 bits), generator polynomial and start value are run-time settings. The engine samples them together with the direction, word and word length on a start pulse, and holds them for the whole frame. With a 4-bit length, polynomial 0001 and start value 1010, a word of all zeros yields 1010. Under that setup, an all-zero frame with a zero check field, which is what the line returns when no sensor answers, is reported as an error. Other settings may accept such a frame.

Top module: `crc_serial_engine`

## Requirements
- R1: In send mode (`rx_mode`=0), starting the cycle after an accepted `start`, `tx_vld` is high for one cycle per bit and `tx_bit` carries the latched word's low `data_len` bits, most significant first.
- R2: Right after the least significant data bit, the engine sends the CRC bits, most significant first: as many as the CRC length, one per cycle with `tx_vld` high. The CRC value does not change while they are sent.
- R3: Only the low L bits of the CRC register, polynomial and start value are used (L = CRC length). The register starts at the start value masked to L bits. For each data bit it computes feedback = register bit L-1 XOR data bit. It then shifts left by one, fills with 0, drops bits above L-1, and XORs in the masked polynomial when the feedback is 1.
- R4: With L=4, polynomial 0x1 and start value 0xA, an all-zero word of 8 or 16 bits gives `crc_out` = 0xA.
- R5: `done` is a one-cycle pulse in the cycle after the last bit of the frame. `crc_out` shows the CRC computed over the data from that cycle until the next accepted `start`.
- R6: In receive mode (`rx_mode`=1), a bit is taken only in a cycle with `rx_vld` high. The first `data_len` taken bits are data and the next L bits are the received CRC. `err` is high together with `done` exactly when the received CRC differs from the computed one, and is low at every other time.
- R7: An all-zero received frame (zero data and zero CRC) gives `err`=1 with L=4, polynomial 0x1 and start value 0xA. It gives `err`=0 with start value 0.
- R8: A CRC length of 0 means no CRC bits are sent or expected. `done` follows the last data bit, `err` stays low and `crc_out` is 0.
- R9: Direction, word, word length and the three CRC settings are sampled when `start` is accepted. Changes to these inputs during a frame do not affect that frame.
- R10: A `start` pulse while a frame is in progress is ignored.
- R11: A `data_len` below 8 is treated as 8 and one above 16 as 16. A CRC length above 8 is treated as 8.
- R12: During and right after reset, the engine is idle: `tx_vld`, `done` and `err` are low and `crc_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a frame when the engine is idle |
| rx_mode | input | 1 | 0 = send frame, 1 = receive frame |
| data_len | input | 5 | Data word length in bits (8 to 16) |
| tx_word | input | 16 | Word to send (low `data_len` bits used) |
| cfg_len | input | 4 | CRC length in bits (0 to 8) |
| cfg_poly | input | 8 | Generator polynomial (low bits used) |
| cfg_seed | input | 8 | CRC start value (low bits used) |
| tx_bit | output | 1 | Serial output bit |
| tx_vld | output | 1 | Serial output bit is valid |
| rx_bit | input | 1 | Serial input bit |
| rx_vld | input | 1 | Serial input bit is valid |
| done | output | 1 | Frame finished (one-cycle pulse) |
| err | output | 1 | Received CRC mismatch, valid with `done` |
| crc_out | output | 8 | CRC computed over the frame's data |

## Verification
All-zero words under the default 4-bit setup test the start value and the feedback path: a wrong seed or a feedback tap at the wrong bit breaks the expected 1010. Dense non-zero words are run at CRC lengths 5 and 8 with different polynomials, which exposes mask errors and bit-order errors. Zero length checks that the check phase can be skipped. Out-of-range lengths check the clamping. Receive frames cover four cases, each telling apart a different fault in the compare path or the bit-valid gating:
- a correct CRC with back-to-back bits;
- a correct CRC with idle gaps that carry junk on the data line;
- a CRC with one bit flipped;
- the no-response pattern under two start values.

// File: rtl/crc_pkg.sv
package crc_pkg;
    localparam int CW   = 8;
    localparam int LENW = 4;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_DATA,
        PH_CRC,
        PH_FIN
    } phase_t;

    typedef struct packed {
        logic [LENW-1:0] len;
        logic [CW-1:0]   poly;
        logic [CW-1:0]   seed;
    } crc_cfg_t;

    function automatic logic [LENW-1:0] clamp_len(input logic [LENW-1:0] l);
        return (l > LENW'(CW)) ? LENW'(CW) : l;
    endfunction

    function automatic logic [CW-1:0] len_mask(input logic [LENW-1:0] l);
        logic [CW-1:0] m;
        m = '0;
        for (int i = 0; i < CW; i++) begin
            if (i < int'(l)) m[i] = 1'b1;
        end
        return m;
    endfunction

    // One serial update: feedback from the top active bit, shift left, fold in polynomial.
    function automatic logic [CW-1:0] crc_step(input logic [CW-1:0] c, input logic d,
                                               input crc_cfg_t cfg);
        logic [CW-1:0] m;
        logic [CW-1:0] nxt;
        logic          fb;
        m  = len_mask(cfg.len);
        fb = 1'b0;
        for (int i = 0; i < CW; i++) begin
            if (int'(cfg.len) == i + 1) fb = c[i];
        end
        fb  = fb ^ d;
        nxt = (c << 1) & m;
        if (fb) nxt = nxt ^ (cfg.poly & m);
        return nxt;
    endfunction
endpackage

// File: rtl/crc_shift_reg.sv
module crc_shift_reg
    import crc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic          din,
    input  crc_cfg_t      cfg,
    output logic [CW-1:0] crc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            crc <= '0;
        end else if (load) begin
            crc <= cfg.seed & len_mask(cfg.len);
        end else if (step) begin
            crc <= crc_step(crc, din, cfg);
        end
    end
endmodule

// File: rtl/crc_frame_seq.sv
module crc_frame_seq
    import crc_pkg::*;
#(
    parameter int DLW = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            go,
    input  logic            adv,
    input  logic [DLW-1:0]  dlen,
    input  logic [LENW-1:0] clen,
    output phase_t          phase,
    output logic [DLW-1:0]  cnt
);
    localparam logic [DLW-1:0] ONE = DLW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (go) begin
                        phase <= PH_DATA;
                        cnt   <= '0;
                    end
                end
                PH_DATA: begin
                    if (adv) begin
                        if (cnt == dlen - ONE) begin
                            cnt   <= '0;
                            phase <= (clen == '0) ? PH_FIN : PH_CRC;
                        end else begin
                            cnt <= cnt + ONE;
                        end
                    end
                end
                PH_CRC: begin
                    if (adv) begin
                        if (cnt == DLW'(clen) - ONE) begin
                            cnt   <= '0;
                            phase <= PH_FIN;
                        end else begin
                            cnt <= cnt + ONE;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/crc_rx_capture.sv
module crc_rx_capture
    import crc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          shift,
    input  logic          din,
    output logic [CW-1:0] cap
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cap <= '0;
        end else if (shift) begin
            cap <= {cap[CW-2:0], din};
        end
    end
endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine
    import crc_pkg::*;
#(
    parameter  int DATA_W   = 16,
    parameter  int DATA_MIN = 8,
    localparam int DLW      = $clog2(DATA_W + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            rx_mode,
    input  logic [DLW-1:0]  data_len,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [LENW-1:0] cfg_len,
    input  logic [CW-1:0]   cfg_poly,
    input  logic [CW-1:0]   cfg_seed,
    output logic            tx_bit,
    output logic            tx_vld,
    input  logic            rx_bit,
    input  logic            rx_vld,
    output logic            done,
    output logic            err,
    output logic [CW-1:0]   crc_out
);
    phase_t            st;
    logic [DLW-1:0]    cnt;
    crc_cfg_t          cfg_q;
    crc_cfg_t          cfg_new;
    crc_cfg_t          cfg_use;
    logic [DLW-1:0]    len_q;
    logic [DLW-1:0]    len_new;
    logic [DATA_W-1:0] word_q;
    logic              mode_q;
    logic [CW-1:0]     crc_q;
    logic [CW-1:0]     cap_q;
    logic              go;
    logic              busy;
    logic              adv;
    logic              din;
    logic [DLW-1:0]    didx;
    logic [LENW-1:0]   cidx;
    logic [DATA_W-1:0] word_sh;
    logic [CW-1:0]     crc_sh;

    assign go   = start && (st == PH_IDLE);
    assign busy = (st == PH_DATA) || (st == PH_CRC);
    assign adv  = busy && (mode_q ? rx_vld : 1'b1);

    always_comb begin
        cfg_new.len  = clamp_len(cfg_len);
        cfg_new.poly = cfg_poly;
        cfg_new.seed = cfg_seed;
        if (data_len < DLW'(DATA_MIN))    len_new = DLW'(DATA_MIN);
        else if (data_len > DLW'(DATA_W)) len_new = DLW'(DATA_W);
        else                              len_new = data_len;
    end

    assign cfg_use = go ? cfg_new : cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            len_q  <= DLW'(DATA_MIN);
            word_q <= '0;
            mode_q <= 1'b0;
        end else if (go) begin
            cfg_q  <= cfg_new;
            len_q  <= len_new;
            word_q <= tx_word;
            mode_q <= rx_mode;
        end
    end

    // Bit selection by shifting, so index widths need not match the vectors.
    assign didx    = len_q - DLW'(1) - cnt;
    assign cidx    = cfg_q.len - LENW'(1) - LENW'(cnt);
    assign word_sh = word_q >> didx;
    assign crc_sh  = crc_q >> cidx;
    assign din     = mode_q ? rx_bit : word_sh[0];

    crc_frame_seq #(.DLW(DLW)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .go    (go),
        .adv   (adv),
        .dlen  (len_q),
        .clen  (cfg_q.len),
        .phase (st),
        .cnt   (cnt)
    );

    crc_shift_reg u_lfsr (
        .clk  (clk),
        .rst  (rst),
        .load (go),
        .step (adv && (st == PH_DATA)),
        .din  (din),
        .cfg  (cfg_use),
        .crc  (crc_q)
    );

    crc_rx_capture u_cap (
        .clk   (clk),
        .rst   (rst),
        .clear (go),
        .shift (adv && (st == PH_CRC) && mode_q),
        .din   (rx_bit),
        .cap   (cap_q)
    );

    assign tx_vld  = busy && !mode_q;
    assign tx_bit  = tx_vld && ((st == PH_DATA) ? word_sh[0] : crc_sh[0]);
    assign done    = (st == PH_FIN);
    assign err     = done && mode_q && (cfg_q.len != '0) && (cap_q != crc_q);
    assign crc_out = crc_q;
endmodule

// File: rtl/crc_serial_checker.sv
module crc_serial_checker
    import crc_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          done,
    input logic          err,
    input logic          tx_vld,
    input phase_t        st,
    input logic [CW-1:0] crc,
    input crc_cfg_t      cfg
);
    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r5_done_after_bits: assert property (@(posedge clk) disable iff (rst)
        done |-> !tx_vld);

    a_r6_err_with_done: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    a_r2_crc_held: assert property (@(posedge clk) disable iff (rst)
        (st == PH_CRC) |=> $stable(crc));

    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        ((st != PH_IDLE) && ($past(st) != PH_IDLE)) |-> $stable(cfg));

    a_r11_len_bound: assert property (@(posedge clk) disable iff (rst)
        (st != PH_IDLE) |-> (cfg.len <= LENW'(CW)));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (st == PH_IDLE) |-> (!tx_vld && !done));
endmodule

bind crc_serial_engine crc_serial_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .done   (done),
    .err    (err),
    .tx_vld (tx_vld),
    .st     (st),
    .crc    (crc_q),
    .cfg    (cfg_q)
);

// File: tb/crc_serial_engine_bench.sv
module crc_serial_engine_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        rx_mode = 1'b0;
    logic [4:0]  data_len = 5'd8;
    logic [15:0] tx_word = '0;
    logic [3:0]  cfg_len = 4'd4;
    logic [7:0]  cfg_poly = 8'h01;
    logic [7:0]  cfg_seed = 8'h0A;
    logic        tx_bit;
    logic        tx_vld;
    logic        rx_bit = 1'b0;
    logic        rx_vld = 1'b0;
    logic        done;
    logic        err;
    logic [7:0]  crc_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    crc_serial_engine u_crc_serial_engine (
        .clk(clk), .rst(rst), .start(start), .rx_mode(rx_mode), .data_len(data_len),
        .tx_word(tx_word), .cfg_len(cfg_len), .cfg_poly(cfg_poly), .cfg_seed(cfg_seed),
        .tx_bit(tx_bit), .tx_vld(tx_vld), .rx_bit(rx_bit), .rx_vld(rx_vld),
        .done(done), .err(err), .crc_out(crc_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int eff_dlen(input int d);
        return (d < 8) ? 8 : ((d > 16) ? 16 : d);
    endfunction

    function automatic int eff_clen(input int c);
        return (c > 8) ? 8 : c;
    endfunction

    function automatic int ref_crc(input int word, input int dl, input int cl,
                                   input int poly, input int seed);
        int c, m, fb;
        if (cl == 0) return 0;
        m = (1 << cl) - 1;
        c = seed & m;
        for (int i = dl - 1; i >= 0; i--) begin
            fb = ((c >> (cl - 1)) ^ (word >> i)) & 1;
            c  = (c << 1) & m;
            if (fb != 0) c = c ^ (poly & m);
        end
        return c;
    endfunction

    task automatic run_tx(input string req, input int dl, input int w, input int cl,
                          input int p, input int s, input bit disturb);
        int q[$];
        int edl, ecl, exp_crc, pos;
        edl     = eff_dlen(dl);
        ecl     = eff_clen(cl);
        exp_crc = ref_crc(w, edl, ecl, p, s);
        for (int i = edl - 1; i >= 0; i--) q.push_back((w >> i) & 1);
        for (int i = ecl - 1; i >= 0; i--) q.push_back((exp_crc >> i) & 1);
        rx_mode  = 1'b0;
        data_len = 5'(dl);
        tx_word  = 16'(w);
        cfg_len  = 4'(cl);
        cfg_poly = 8'(p);
        cfg_seed = 8'(s);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            tx_word  = ~16'(w);
            data_len = 5'd9;
            cfg_len  = 4'd2;
            cfg_poly = ~8'(p);
            cfg_seed = ~8'(s);
        end
        pos = 0;
        while (q.size() > 0) begin
            int b;
            b = q.pop_front();
            chk({req, " tx_vld"}, int'(tx_vld), 1);
            chk({req, (pos < edl) ? " data bit R1" : " crc bit R2"}, int'(tx_bit), b);
            chk({req, " done low mid-frame R5"}, int'(done), 0);
            start = (disturb && pos == 1) ? 1'b1 : 1'b0;
            pos++;
            @(negedge clk);
        end
        start = 1'b0;
        chk({req, " done pulse R5"}, int'(done), 1);
        chk({req, " tx err low R6"}, int'(err), 0);
        chk({req, " crc_out R3"}, int'(crc_out), exp_crc);
        @(negedge clk);
        chk({req, " done single R5"}, int'(done), 0);
        chk({req, " tx_vld idle R10"}, int'(tx_vld), 0);
        chk({req, " crc_out held R5"}, int'(crc_out), exp_crc);
    endtask

    task automatic run_rx(input string req, input int dl, input int w, input int cl,
                          input int p, input int s, input int sent, input int gap);
        int q[$];
        int edl, ecl, exp_crc, exp_err;
        edl     = eff_dlen(dl);
        ecl     = eff_clen(cl);
        exp_crc = ref_crc(w, edl, ecl, p, s);
        exp_err = (ecl != 0 && sent != exp_crc) ? 1 : 0;
        for (int i = edl - 1; i >= 0; i--) q.push_back((w >> i) & 1);
        for (int i = ecl - 1; i >= 0; i--) q.push_back((sent >> i) & 1);
        rx_mode  = 1'b1;
        data_len = 5'(dl);
        cfg_len  = 4'(cl);
        cfg_poly = 8'(p);
        cfg_seed = 8'(s);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (q.size() > 0) begin
            int b;
            b = q.pop_front();
            for (int g = 0; g < gap; g++) begin
                rx_vld = 1'b0;
                rx_bit = ~1'(b);
                chk({req, " idle gap no done R6"}, int'(done), 0);
                chk({req, " no tx in rx R6"}, int'(tx_vld), 0);
                @(negedge clk);
            end
            rx_vld = 1'b1;
            rx_bit = 1'(b);
            chk({req, " rx done low mid-frame R6"}, int'(done), 0);
            @(negedge clk);
        end
        rx_vld = 1'b0;
        rx_bit = 1'b0;
        chk({req, " rx done pulse R5"}, int'(done), 1);
        chk({req, " rx err R6"}, int'(err), exp_err);
        chk({req, " rx crc_out R3"}, int'(crc_out), exp_crc);
        @(negedge clk);
        chk({req, " rx done single R5"}, int'(done), 0);
        chk({req, " err clears R6"}, int'(err), 0);
    endtask

    initial begin : watchdog
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("reset tx_vld R12", int'(tx_vld), 0);
        chk("reset done R12", int'(done), 0);
        chk("reset err R12", int'(err), 0);
        chk("reset crc_out R12", int'(crc_out), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("post-reset idle R12", int'(tx_vld), 0);

        run_tx("R4 default zero 8b", 8, 0, 4, 1, 10, 1'b0);
        chk("R4 crc 8b", int'(crc_out), 10);
        run_tx("R4 default zero 16b", 16, 0, 4, 1, 10, 1'b0);
        chk("R4 crc 16b", int'(crc_out), 10);
        run_tx("R3 12b len8", 12, 'hA5C, 8, 'h07, 'hFF, 1'b0);
        run_tx("R3 16b len5", 16, 'hC3A1, 5, 'h05, 'h13, 1'b0);
        run_tx("R8 tx no crc", 10, 'h2B7, 0, 'h07, 'hFF, 1'b0);
        chk("R8 crc_out zero", int'(crc_out), 0);
        run_tx("R9 R10 disturbed", 16, 'hBEEF, 5, 'h05, 'h1F, 1'b1);
        run_tx("R11 long clamp", 20, 'h9D4E, 13, 'h31, 'h5A, 1'b0);
        run_tx("R11 short clamp", 3, 'h96, 4, 'h03, 'h06, 1'b0);

        run_rx("R6 good crc", 12, 'h5E1, 8, 'h07, 'hFF, ref_crc('h5E1, 12, 8, 'h07, 'hFF), 0);
        run_rx("R6 good crc gaps", 16, 'h1234, 6, 'h21, 'h2A, ref_crc('h1234, 16, 6, 'h21, 'h2A), 2);
        run_rx("R6 bad crc", 9, 'h1A5, 4, 'h03, 'h0A, ref_crc('h1A5, 9, 4, 'h03, 'h0A) ^ 1, 1);
        run_rx("R7 no response default", 8, 0, 4, 1, 10, 0, 0);
        run_rx("R7 no response zero seed", 8, 0, 4, 1, 0, 0, 0);
        run_rx("R8 rx no crc", 8, 'hF0, 0, 'h07, 'hFF, 0, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule